// File: doc/BRIEF.md
# Interrupt Source Enable and Status Register

This block gathers up to eight edge-triggered event inputs into a single active-high interrupt request. One 8-bit register does two jobs: a write loads the enable mask, and a read returns which enabled sources have fired and are still latched. No separate clear register exists. Software acknowledges a source by writing its enable bit low, which also clears its latched status. Writing the bit high again re-arms the source.

An interrupt handler uses the block in a loop. It reads the status, masks off the sources it has seen and writes the reduced mask, and it repeats this until the status reads zero. It then restores the full mask. Only sources named in the `VALID_MASK` parameter exist. Every other bit reads as zero and never fires. The request output is the OR of all latched status bits, taken through one register stage.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the enable mask is zero, status_o reads 0x00 and irq_o is low.
- R2: A rising edge on src_i[n] sets status bit n at the next clock edge when bit n was enabled in the cycle of the edge. An input held high produces no further edge.
- R3: A rising edge on a source whose enable bit is 0 leaves its status bit at 0.
- R4: A write clears the status bit of every source whose new enable bit is 0. Writing 0x00 clears all status. Re-enabling a source re-arms it for its next rising edge.
- R5: A rising edge that arrives in the same cycle as a write is discarded when either the old or the new enable bit of that source is 0.
- R6: Bits outside VALID_MASK ignore writes and edges and always read as 0. The default mask is 0xDF, so bit 5 is unimplemented.
- R7: irq_o equals the OR of status_o as it was one clock cycle earlier.
- R8: A rising edge on a source whose status bit is already set is merged. The bit stays set, and irq_o stays high without dropping.
- R9: A write that keeps a source enabled preserves that source's latched status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | New enable mask, bit n enables source n |
| src_i | input | 8 | Event inputs, rising-edge sensitive |
| status_o | output | 8 | Latched status of enabled sources that have fired |
| irq_o | output | 1 | Registered OR of the status bits |

## Verification
The bench raises an edge in the same cycle as a write that disables its source, and in the same cycle as a write that enables it. A design that used only the old mask or only the new mask would latch one of these edges and show a spurious status bit.

It keeps an input high across a disable and re-enable pair. A level-sensitive design would re-fire there at once, and the acknowledge loop would never finish.

It pulses a source again while its bit is already set, and checks that irq_o never dips. It also rewrites the mask while keeping one source enabled, and checks that this source's pending status survives. A design that cleared all status on every write would lose that event.

Finally it drives the unimplemented bit, where any leakage would show up as a non-zero bit 5 on status_o.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    // Width of the shared enable/status register.
    localparam int SRC_W = 8;

    typedef logic [SRC_W-1:0] src_vec_t;

    // State of the edge detector: last sampled input level.
    typedef struct packed {
        src_vec_t prev;
    } edge_state_t;

    // State of the status bank: enable mask and latched status.
    typedef struct packed {
        src_vec_t en;
        src_vec_t stat;
    } bank_state_t;

    // State of the request stage.
    typedef struct packed {
        logic req;
    } req_state_t;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_src_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  src_vec_t src_i,
    output src_vec_t rise_o
);

    edge_state_t cur_q;
    edge_state_t nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = src_i;
    end

    // A bit rises when it is high now and was low in the last sample.
    for (genvar i = 0; i < SRC_W; i++) begin : g_rise
        assign rise_o[i] = src_i[i] & ~cur_q.prev[i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_src_pkg::*;
#(
    parameter src_vec_t VALID_MASK = 8'hDF
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     wr_en_i,
    input  src_vec_t wr_data_i,
    input  src_vec_t rise_i,
    output src_vec_t en_o,
    output src_vec_t stat_o
);

    bank_state_t cur_q;
    bank_state_t nxt_d;
    src_vec_t    arm;

    always_comb begin
        nxt_d = cur_q;
        // Only sources enabled during this cycle may latch.
        arm        = rise_i & cur_q.en & VALID_MASK;
        nxt_d.stat = cur_q.stat | arm;
        if (wr_en_i) begin
            nxt_d.en   = wr_data_i & VALID_MASK;
            // A dropped enable clears its status, including an edge arriving now.
            nxt_d.stat = nxt_d.stat & nxt_d.en;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign en_o   = cur_q.en;
    assign stat_o = cur_q.stat;

    // R3: a status bit only rises where the source was enabled.
    assert_no_set_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cur_q.stat & ~$past(cur_q.stat) & ~$past(cur_q.en)) == '0));

    // R4: after a write, no status bit survives outside the written mask.
    assert_disable_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> ((cur_q.stat & ~$past(wr_data_i)) == '0));

    // R8: without a write, a latched bit never drops.
    assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> ((~cur_q.stat & $past(cur_q.stat)) == '0));

    // R2: a rising edge on an enabled source with no write latches.
    assert_edge_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && ((rise_i & cur_q.en) != '0))
            |=> ((cur_q.stat & $past(rise_i & cur_q.en)) == $past(rise_i & cur_q.en)));

endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
    import irq_src_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  src_vec_t stat_i,
    output logic     req_o
);

    req_state_t cur_q;
    req_state_t nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.req = |stat_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_o = cur_q.req;

    // R7: the request follows the status OR by exactly one cycle.
    assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (req_o == $past(|stat_i)));

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter src_vec_t VALID_MASK = 8'hDF
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] src_i,
    output logic [7:0] status_o,
    output logic       irq_o
);

    src_vec_t rise;
    src_vec_t en;
    src_vec_t stat;

    irq_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irq_status_bank #(
        .VALID_MASK (VALID_MASK)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rise_i    (rise),
        .en_o      (en),
        .stat_o    (stat)
    );

    irq_req_reg u_req (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stat_i (stat),
        .req_o  (irq_o)
    );

    assign status_o = stat;

    // R6: unimplemented bits never appear in the mask or on the read side.
    assert_reserved_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((status_o | en) & ~VALID_MASK) == '0));

    // R4: a pending bit is never reported for a source that is disabled.
    assert_stat_within_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & ~en) == '0));

endmodule

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;

    localparam logic [7:0] VM = 8'hDF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] src = '0;
    logic [7:0] status;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_src_ctrl #(.VALID_MASK(VM)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .src_i     (src),
        .status_o  (status),
        .irq_o     (irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] m);
        wr_en = 1'b1; wr_data = m;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic settle();
        src = '0; tick();
        wr(8'h00); tick();
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_edge_and_ack();
        wr(8'hFF);
        src[0] = 1'b1; tick();
        chk("R2 status set", status, 8'h01);
        chk("R7 irq lags", {7'd0, irq}, 8'h00);
        tick();
        chk("R7 irq up", {7'd0, irq}, 8'h01);
        wr(8'hFE);
        chk("R4 ack clears", status, 8'h00);
        chk("R7 irq still up", {7'd0, irq}, 8'h01);
        wr(8'hFF);
        chk("R7 irq falls", {7'd0, irq}, 8'h00);
        tick(); tick();
        chk("R2 held level no refire", status, 8'h00);
        src[0] = 1'b0; tick();
        src[0] = 1'b1; tick();
        chk("R4 rearmed", status, 8'h01);
        settle();
    endtask

    task automatic t_disabled();
        wr(8'h0F);
        src[6] = 1'b1; tick(); tick();
        chk("R3 disabled ignored", status, 8'h00);
        chk("R3 irq low", {7'd0, irq}, 8'h00);
        settle();
    endtask

    task automatic t_same_cycle();
        wr(8'hFF);
        src[2] = 1'b1; wr_en = 1'b1; wr_data = 8'hFB;
        tick(); wr_en = 1'b0;
        chk("R5 edge with disable", status, 8'h00);
        wr(8'hFF); tick();
        chk("R5 no late latch", status, 8'h00);
        settle();
        wr(8'h00);
        src[3] = 1'b1; wr_en = 1'b1; wr_data = 8'h08;
        tick(); wr_en = 1'b0;
        chk("R5 edge with enable", status, 8'h00);
        settle();
    endtask

    task automatic t_reserved();
        wr(8'hFF);
        src[5] = 1'b1; tick(); tick();
        chk("R6 bit5 reads 0", status, 8'h00);
        chk("R6 irq low", {7'd0, irq}, 8'h00);
        settle();
    endtask

    task automatic t_merge();
        logic dip;
        wr(8'hFF);
        src[1] = 1'b1; tick(); tick();
        chk("R8 first", status, 8'h02);
        dip = 1'b0;
        src[1] = 1'b0; tick(); if (!irq) dip = 1'b1;
        src[1] = 1'b1; tick(); if (!irq) dip = 1'b1;
        tick(); if (!irq) dip = 1'b1;
        chk("R8 merged", status, 8'h02);
        chk("R8 irq no dip", {7'd0, dip}, 8'h00);
        settle();
    endtask

    task automatic t_keep();
        wr(8'hFF);
        src[0] = 1'b1; src[1] = 1'b1; tick();
        chk("R2 two sources", status, 8'h03);
        wr(8'h02);
        chk("R9 kept status", status, 8'h02);
        wr(8'h00);
        chk("R4 write zero clears", status, 8'h00);
        tick();
        chk("R7 irq low after clear", {7'd0, irq}, 8'h00);
        settle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_edge_and_ack();
        t_disabled();
        t_same_cycle();
        t_reserved();
        t_merge();
        t_keep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule